// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Reassert Spacing

This block gathers event flags from the chip core and from up to eight network sockets into sticky status registers. Each event arrives as a single-cycle pulse and sets its bit, which stays set until software clears it by writing a one to that bit. A per-socket summary register shows which sockets have any flag pending. Two enable masks decide which chip-level bits and which socket summary bits may drive the interrupt pin.

The pin is active low. Once it releases, it may not fall again until a programmable hold-off has elapsed. The hold-off is (level+1)*4 clock cycles, where level is a 16-bit value split across two byte registers. A level of zero removes the hold-off. Software reaches every register through a simple byte-wide write port with a combinational read path.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status, flag, mask and level register reads 0x00, and irq_n_o is high.
- R2: A pulse on chip_evt_i sets the matching bit of the chip status register (address 0x00). Only bit 7 (address conflict), bit 6 (destination unreachable) and bit 4 (wake request) are kept. Bits 5 and 3..0 ignore events and always read 0.
- R3: A pulse on sock_evt_i[n*5 +: 5] sets flag bits 4..0 of socket n, which read at address 0x08+n. The bits are: 4 send complete, 3 timeout, 2 data received, 1 FIN received, 0 connection. Bits 7..5 read 0.
- R4: Writing a data bit of 1 to address 0x00 or 0x08+n clears that status bit. Writing 0 leaves the bit unchanged.
- R5: When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R6: Bit n of the read-only socket summary at address 0x02 is 1 exactly while socket n has any flag set. Writes to 0x02 have no effect.
- R7: The chip mask at address 0x01 enables a status bit with 1. irq_n_o goes low one cycle after an enabled status bit becomes set. Set bits that are masked do not pull the pin low.
- R8: The socket mask at address 0x03 enables summary bit n with 1. Only enabled pending sockets pull the pin low.
- R9: irq_n_o returns high one cycle after the last enabled pending bit is cleared or masked.
- R10: Let level = {reg 0x04, reg 0x05}. When level is nonzero, irq_n_o stays high for exactly (level+1)*4 cycles after a release before it may fall again, even if an enabled bit is pending during that time.
- R11: With level zero, irq_n_o may fall again in the cycle right after the one in which it went high.
- R12: The chip mask, socket mask and both level bytes read back exactly the byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_evt_i | input | 8 | Chip-level event pulses, one bit per status bit |
| sock_evt_i | input | NUM_SOCK*5 | Per-socket event pulses, 5 bits per socket |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address for both read and write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| irq_n_o | output | 1 | Interrupt pin, active low |

## Verification
The hardest case to reach is the reassert spacing. It needs a release followed at once by a fresh enabled event, so that the pin wants to fall while the hold-off is still counting. The stimulus first clears the only pending bit with a write. In the very next cycle it pulses the same event again, then counts how many sampled cycles the pin stays high. It does this with level 1 and with level 0. A related timing case is a clear that lands in the same cycle as its event. The bench drives the write strobe and the event pulse on the same edge to create it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W      = 5;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned SFLAG_W     = 5;
  localparam int unsigned LEVEL_W     = 16;
  localparam int unsigned MAX_SOCK    = 8;

  localparam logic [ADDR_W-1:0] A_CHIP_STAT = 5'h00;
  localparam logic [ADDR_W-1:0] A_CHIP_MASK = 5'h01;
  localparam logic [ADDR_W-1:0] A_SOCK_SUM  = 5'h02;
  localparam logic [ADDR_W-1:0] A_SOCK_MASK = 5'h03;
  localparam logic [ADDR_W-1:0] A_LEVEL_HI  = 5'h04;
  localparam logic [ADDR_W-1:0] A_LEVEL_LO  = 5'h05;
  localparam logic [1:0]        A_SOCK_PAGE = 2'b01;

  localparam logic [BYTE_W-1:0]  CHIP_VALID = 8'hD0;
  localparam logic [SFLAG_W-1:0] SOCK_VALID = 5'h1F;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned         WIDTH = 8,
  parameter logic [WIDTH-1:0]    VALID = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] flags_q, flags_d;
  logic             upd_en;

  always_comb begin
    upd_en  = (|evt_i) | (|clr_i);
    flags_d = ((flags_q & ~clr_i) | evt_i) & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R2
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & VALID)) |=> ((flags_q & $past(evt_i & VALID)) == $past(evt_i & VALID)));
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~evt_i)) |=> ((flags_q & $past(clr_i & ~evt_i)) == '0));
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~VALID) == '0));
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int unsigned LEVEL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               want_i,
  input  logic [LEVEL_W-1:0] level_i,
  output logic               irq_n_o
);
  localparam int unsigned CNT_W = LEVEL_W + 2;

  logic             pin_q, pin_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    pin_d = pin_q;
    cnt_d = cnt_q;
    if (pin_q) begin
      if (!want_i) begin
        pin_d = 1'b0;
        cnt_d = (level_i != '0) ? {level_i, 2'b11} : '0;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else if (want_i) begin
      pin_d = 1'b1;
    end
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pin_q <= pin_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign irq_n_o = ~pin_q;

  // R10
  no_early_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> ($past(cnt_q) == '0));
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !want_i) |=> irq_n_o);
  // R7
  assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n_o && want_i && cnt_q == '0) |=> !irq_n_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SOCK = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BYTE_W-1:0]           chip_evt_i,
  input  logic [NUM_SOCK*SFLAG_W-1:0] sock_evt_i,
  input  logic                        reg_wr_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic [BYTE_W-1:0]           reg_wdata_i,
  output logic [BYTE_W-1:0]           reg_rdata_o,
  output logic                        irq_n_o
);
  localparam int unsigned SIDX_W = $clog2(MAX_SOCK);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // write decode
  logic wr_cmask, wr_smask, wr_lhi, wr_llo, wr_cstat;
  always_comb begin
    wr_cstat = reg_wr_i && (reg_addr_i == A_CHIP_STAT);
    wr_cmask = reg_wr_i && (reg_addr_i == A_CHIP_MASK);
    wr_smask = reg_wr_i && (reg_addr_i == A_SOCK_MASK);
    wr_lhi   = reg_wr_i && (reg_addr_i == A_LEVEL_HI);
    wr_llo   = reg_wr_i && (reg_addr_i == A_LEVEL_LO);
  end

  // configuration registers
  logic [BYTE_W-1:0]  cmask_q, smask_q;
  logic [LEVEL_W-1:0] level_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmask_q <= '0;
      smask_q <= '0;
      level_q <= '0;
    end else begin
      if (wr_cmask) cmask_q <= reg_wdata_i;
      if (wr_smask) smask_q <= reg_wdata_i;
      if (wr_lhi)   level_q[15:8] <= reg_wdata_i;
      if (wr_llo)   level_q[7:0]  <= reg_wdata_i;
    end
  end

  // chip status
  logic [BYTE_W-1:0] cstat, cclr;
  assign cclr = wr_cstat ? reg_wdata_i : '0;

  irq_flag_bank #(.WIDTH(BYTE_W), .VALID(CHIP_VALID)) u_chip_bank (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .evt_i  (chip_evt_i),
    .clr_i  (cclr),
    .flags_o(cstat)
  );

  // per-socket flags and summary
  logic [SFLAG_W-1:0] sflags [MAX_SOCK];
  logic [BYTE_W-1:0]  summary;

  for (genvar n = 0; n < MAX_SOCK; n++) begin : g_sock
    if (n < NUM_SOCK) begin : g_live
      logic               hit;
      logic [SFLAG_W-1:0] sclr;
      assign hit  = reg_wr_i && (reg_addr_i[4:3] == A_SOCK_PAGE) &&
                    (reg_addr_i[2:0] == SIDX_W'(n));
      assign sclr = hit ? reg_wdata_i[SFLAG_W-1:0] : '0;

      irq_flag_bank #(.WIDTH(SFLAG_W), .VALID(SOCK_VALID)) u_sock_bank (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .evt_i  (sock_evt_i[n*SFLAG_W +: SFLAG_W]),
        .clr_i  (sclr),
        .flags_o(sflags[n])
      );
    end else begin : g_idle
      assign sflags[n] = '0;
    end
    assign summary[n] = |sflags[n];
  end

  // pin request
  logic want;
  assign want = (|(cstat & cmask_q)) | (|(summary & smask_q));

  irq_holdoff #(.LEVEL_W(LEVEL_W)) u_holdoff (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .want_i (want),
    .level_i(level_q),
    .irq_n_o(irq_n_o)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[4:3] == A_SOCK_PAGE) begin
      reg_rdata_o = {{(BYTE_W-SFLAG_W){1'b0}}, sflags[reg_addr_i[2:0]]};
    end else begin
      case (reg_addr_i)
        A_CHIP_STAT: reg_rdata_o = cstat;
        A_CHIP_MASK: reg_rdata_o = cmask_q;
        A_SOCK_SUM:  reg_rdata_o = summary;
        A_SOCK_MASK: reg_rdata_o = smask_q;
        A_LEVEL_HI:  reg_rdata_o = level_q[15:8];
        A_LEVEL_LO:  reg_rdata_o = level_q[7:0];
        default:     reg_rdata_o = '0;
      endcase
    end
  end

  // R6
  summary_ro_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr_i && reg_addr_i == A_SOCK_SUM && $stable(sock_evt_i) && sock_evt_i == '0)
      |=> $stable(summary));
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    chip_evt;
  logic [NS*5-1:0] sock_evt;
  logic          wr;
  logic [4:0]    addr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          irq_n;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [4:0] a;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];
  logic probe = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator #(.NUM_SOCK(NS)) u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .chip_evt_i(chip_evt), .sock_evt_i(sock_evt),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_n_o(irq_n)
  );

  // monitor: pops expected read items
  always @(negedge clk) begin
    if (probe) begin
      n_tests++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL monitor: no expected item, got %02h", rdata);
      end else begin
        item_t it;
        it = q.pop_front();
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: addr %02h actual %02h expected %02h", it.tag, it.a, rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.a = a; it.exp = e; it.tag = tag;
    addr = a;
    q.push_back(it);
    probe = 1'b1;
    @(negedge clk); #1 probe = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic wrr(input logic [4:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic cpulse(input logic [7:0] e);
    chip_evt = e;
    @(posedge clk); #1 chip_evt = '0;
  endtask

  task automatic spulse(input int s, input logic [4:0] e);
    sock_evt[s*5 +: 5] = e;
    @(posedge clk); #1 sock_evt = '0;
  endtask

  task automatic check_pin(input logic e, input string tag);
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (irq_n !== e) begin
      n_fail++;
      $display("FAIL %s: irq_n actual %0b expected %0b", tag, irq_n, e);
    end
    @(posedge clk); #1;
  endtask

  // clear bit 7 then re-raise it next cycle; count high cycles
  task automatic spacing(input int exp, input string tag);
    int cnt;
    cnt = 0;
    wrr(5'h00, 8'h80);
    cpulse(8'h80);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (irq_n === 1'b1) cnt++;
      else break;
    end
    n_tests++;
    if (cnt != exp) begin
      n_fail++;
      $display("FAIL %s: high cycles actual %0d expected %0d", tag, cnt, exp);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chip_evt = '0; sock_evt = '0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    rd(5'h00, 8'h00, "R1 chip status");
    rd(5'h01, 8'h00, "R1 chip mask");
    rd(5'h02, 8'h00, "R1 summary");
    rd(5'h04, 8'h00, "R1 level hi");
    rd(5'h0B, 8'h00, "R1 socket 3 flags");
    check_pin(1'b1, "R1 pin idle");

    // R12 readback
    wrr(5'h01, 8'h5A); rd(5'h01, 8'h5A, "R12 chip mask");
    wrr(5'h03, 8'hA5); rd(5'h03, 8'hA5, "R12 socket mask");
    wrr(5'h04, 8'h01); wrr(5'h05, 8'h02);
    rd(5'h04, 8'h01, "R12 level hi"); rd(5'h05, 8'h02, "R12 level lo");
    wrr(5'h01, 8'h00); wrr(5'h03, 8'h00); wrr(5'h04, 8'h00); wrr(5'h05, 8'h00);

    // R2 chip events, reserved bits dropped; R7 masked does not drive pin
    cpulse(8'hFF);
    rd(5'h00, 8'hD0, "R2 chip status capture");
    check_pin(1'b1, "R7 masked bits keep pin high");
    wrr(5'h01, 8'h10);
    check_pin(1'b0, "R7 enabled bit pulls pin low");
    // R4 clear
    wrr(5'h00, 8'h10);
    rd(5'h00, 8'hC0, "R4 write-one clears");
    check_pin(1'b1, "R9 pin releases");
    wrr(5'h00, 8'h00);
    rd(5'h00, 8'hC0, "R4 write-zero keeps");
    wrr(5'h00, 8'hC0);
    rd(5'h00, 8'h00, "R4 clear rest");

    // R3 socket flags, R6 summary
    spulse(3, 5'h1F);
    rd(5'h0B, 8'h1F, "R3 socket 3 flags");
    rd(5'h0A, 8'h00, "R3 socket 2 untouched");
    rd(5'h02, 8'h08, "R6 summary bit 3");
    wrr(5'h02, 8'hFF);
    rd(5'h02, 8'h08, "R6 summary write ignored");
    check_pin(1'b1, "R8 socket masked");
    wrr(5'h03, 8'h08);
    check_pin(1'b0, "R8 socket enabled");
    wrr(5'h0B, 8'h01);
    rd(5'h0B, 8'h1E, "R4 socket clear bit 0");
    check_pin(1'b0, "R8 still pending");
    wrr(5'h0B, 8'h1E);
    rd(5'h02, 8'h00, "R6 summary clears");
    check_pin(1'b1, "R9 socket release");
    wrr(5'h03, 8'h00);

    // R5 event and clear together
    wr = 1'b1; addr = 5'h00; wdata = 8'h80; chip_evt = 8'h80;
    @(posedge clk); #1 wr = 1'b0; chip_evt = '0;
    rd(5'h00, 8'h80, "R5 event beats clear");

    // R10 hold-off with level 1 -> 8 cycles
    wrr(5'h01, 8'h80);
    check_pin(1'b0, "R7 bit 7 enabled");
    wrr(5'h05, 8'h01);
    spacing(8, "R10 level 1 spacing");
    // R11 level 0 -> 1 cycle
    wrr(5'h05, 8'h00);
    spacing(1, "R11 level 0 spacing");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule